// File: doc/BRIEF.md
# Sliding-Window SHA-256 Message Schedule

This block supplies the 64 message-schedule words W0..W63 that the SHA-256 compression rounds consume for one 512-bit block. It holds only sixteen 32-bit registers. A 64-entry memory with address decode is not needed. A start strobe copies the block into the sixteen registers, and a round counter goes back to zero.

During the first sixteen rounds the output is the block word that the counter selects, and the registers do not move. From round sixteen on, the output is a word computed from four taps of the window. When the core asks for the next round, that word is written into the top register and every other register moves down one place. The window then always holds the sixteen most recent words.

The output is combinational from the counter and the window. The core reads W for the current round and pulses the step input to advance. Each block is restarted with the start strobe.

Top module: `msg_sched_window`

## Requirements
- R1: While reset (`rst_n` low) is asserted and after it is released, the round counter and all sixteen registers are zero, so `w_o` reads 0 until the first start strobe.
- R2: A start pulse (`start_i` high at a clock edge) loads the registers from `blk_i` and sets the round to 0. Word 0 is `blk_i[511:480]` and word 15 is `blk_i[31:0]`. From that edge on, `w_o` equals word 0. If `start_i` and `step_i` are high together, the start pulse wins.
- R3: For rounds 0..15, `w_o` equals block word t. A step moves the round on by one and leaves the registers unchanged.
- R4: Each step pulse advances the round by exactly one. With neither strobe high, the round and the window hold and `w_o` does not change.
- R5: For rounds t = 16..63, `w_o` = s1(W[t-2]) + W[t-7] + s0(W[t-15]) + W[t-16] mod 2^32. Here s0(x) = ROTR7(x)^ROTR18(x)^SHR3(x) and s1(x) = ROTR17(x)^ROTR19(x)^SHR10(x).
- R6: A step taken at round t >= 16 writes the word shown on `w_o` in that round into the top register and shifts every other register down by one. The following rounds therefore continue the recurrence of R5.
- R7: At round 63 a step pulse is ignored, and `w_o` keeps showing W63.
- R8: A start pulse in the middle of a schedule abandons it and restarts at round 0 with the new block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blk_i | input | 512 | Message block, word 0 in the top 32 bits |
| start_i | input | 1 | Load the block and restart at round 0 |
| step_i | input | 1 | Advance to the next round |
| w_o | output | 32 | Schedule word for the current round |

## Verification
Every result appears after a single register stage. `w_o` takes its new value one rising edge after a start or step strobe, because the counter and window are the only state and the output is combinational from them. The bench changes strobes for exactly one cycle between two falling edges and compares `w_o` at the next falling edge, after the update edge and before any other edge. Idle and saturation checks wait extra cycles before they sample, to show that nothing moved.

// File: rtl/msw_pkg.sv
package msw_pkg;

  localparam int unsigned WORD_W = 32;

  typedef logic [WORD_W-1:0] word_t;

  // right rotate by a constant amount
  function automatic word_t rotr(input word_t x, input int unsigned n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

  function automatic word_t small_sig0(input word_t x);
    return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
  endfunction

  function automatic word_t small_sig1(input word_t x);
    return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
  endfunction

  // recurrence: taps are W[t-2], W[t-7], W[t-15], W[t-16]
  function automatic word_t sched_word(input word_t w_m2, input word_t w_m7,
                                       input word_t w_m15, input word_t w_m16);
    return small_sig1(w_m2) + w_m7 + small_sig0(w_m15) + w_m16;
  endfunction

endpackage

// File: rtl/msw_round_ctr.sv
module msw_round_ctr #(
  parameter int unsigned ROUNDS  = 64,
  parameter int unsigned PRELOAD = 16,
  localparam int unsigned CW = $clog2(ROUNDS),
  localparam int unsigned IW = $clog2(PRELOAD)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          step_i,
  output logic [IW-1:0] idx_o,
  output logic          early_o,
  output logic          shift_o
);

  localparam logic [CW-1:0] LAST = CW'(ROUNDS - 1);
  localparam logic [CW-1:0] PRE  = CW'(PRELOAD);

  logic [CW-1:0] cnt_q;
  logic          at_last;
  logic          advance;

  assign at_last = (cnt_q == LAST);
  assign advance = step_i && !start_i && !at_last;
  assign early_o = (cnt_q < PRE);
  assign idx_o   = cnt_q[IW-1:0];
  assign shift_o = advance && !early_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (start_i) cnt_q <= '0;
    else if (advance) cnt_q <= cnt_q + 1'b1;
  end

  p_start_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (cnt_q == '0));

  p_step_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !start_i && cnt_q != LAST) |=> (cnt_q == $past(cnt_q) + 1'b1));

  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !start_i) |=> $stable(cnt_q));

  p_saturate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (at_last && !start_i) |=> (cnt_q == LAST));

endmodule

// File: rtl/msw_window.sv
module msw_window #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WW    = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load_i,
  input  logic [DEPTH*WW-1:0]        blk_i,
  input  logic                       shift_i,
  input  logic [WW-1:0]              ins_i,
  output logic [DEPTH-1:0][WW-1:0]   win_o
);

  logic [DEPTH-1:0][WW-1:0] win_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [WW-1:0] load_val;
    logic [WW-1:0] shift_val;
    // word 0 sits in the most significant slice of the block
    assign load_val = blk_i[(DEPTH-1-i)*WW +: WW];
    if (i == DEPTH - 1) begin : g_top
      assign shift_val = ins_i;
    end else begin : g_mid
      assign shift_val = win_q[i+1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       win_q[i] <= '0;
      else if (load_i)  win_q[i] <= load_val;
      else if (shift_i) win_q[i] <= shift_val;
    end
  end

  assign win_o = win_q;

  p_top_takes_new_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_i && !load_i) |=> (win_q[DEPTH-1] == $past(ins_i)));

  p_slide_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_i && !load_i) |=> (win_q[0] == $past(win_q[1])));

  p_still_when_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_i && !load_i) |=> $stable(win_q));

endmodule

// File: rtl/msw_expand.sv
module msw_expand
  import msw_pkg::*;
(
  input  word_t tap_m2_i,
  input  word_t tap_m7_i,
  input  word_t tap_m15_i,
  input  word_t tap_m16_i,
  output word_t new_o
);

  assign new_o = sched_word(tap_m2_i, tap_m7_i, tap_m15_i, tap_m16_i);

endmodule

// File: rtl/msw_select.sv
module msw_select #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WW    = 32,
  localparam int unsigned IW = $clog2(DEPTH)
) (
  input  logic                     early_i,
  input  logic [IW-1:0]            idx_i,
  input  logic [DEPTH-1:0][WW-1:0] win_i,
  input  logic [WW-1:0]            new_i,
  output logic [WW-1:0]            w_o
);

  always_comb begin
    if (early_i) w_o = win_i[idx_i];
    else         w_o = new_i;
  end

endmodule

// File: rtl/msg_sched_window.sv
module msg_sched_window
  import msw_pkg::*;
#(
  parameter int unsigned ROUNDS = 64,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned IW = $clog2(DEPTH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [DEPTH*WORD_W-1:0] blk_i,
  input  logic                  start_i,
  input  logic                  step_i,
  output logic [WORD_W-1:0]     w_o
);

  logic [IW-1:0]                idx;
  logic                         early;
  logic                         shift_en;
  logic [DEPTH-1:0][WORD_W-1:0] win;
  word_t                        new_word;

  msw_round_ctr #(.ROUNDS(ROUNDS), .PRELOAD(DEPTH)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .step_i  (step_i),
    .idx_o   (idx),
    .early_o (early),
    .shift_o (shift_en)
  );

  msw_window #(.DEPTH(DEPTH), .WW(WORD_W)) u_win (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (start_i),
    .blk_i   (blk_i),
    .shift_i (shift_en),
    .ins_i   (new_word),
    .win_o   (win)
  );

  msw_expand u_exp (
    .tap_m2_i  (win[DEPTH-2]),
    .tap_m7_i  (win[DEPTH-7]),
    .tap_m15_i (win[1]),
    .tap_m16_i (win[0]),
    .new_o     (new_word)
  );

  msw_select #(.DEPTH(DEPTH), .WW(WORD_W)) u_sel (
    .early_i (early),
    .idx_i   (idx),
    .win_i   (win),
    .new_i   (new_word),
    .w_o     (w_o)
  );

  // the word handed to the core in a shifting round is the one stored
  p_output_stored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !start_i) |=> (win[DEPTH-1] == $past(w_o)));

  p_first_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (w_o == $past(blk_i[DEPTH*WORD_W-1 -: WORD_W])));

endmodule

// File: tb/test_msg_sched_window.sv
module test_msg_sched_window;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [511:0] blk = '0;
  logic         start = 1'b0;
  logic         step = 1'b0;
  logic [31:0]  w;

  int vectors = 0;
  int errors  = 0;

  msg_sched_window i_msg_sched_window (
    .clk     (clk),
    .rst_n   (rst_n),
    .blk_i   (blk),
    .start_i (start),
    .step_i  (step),
    .w_o     (w)
  );

  always #4 clk = ~clk;

  // independent model: rotation via a doubled word
  function automatic logic [31:0] ror(input logic [31:0] x, input int n);
    logic [63:0] d;
    d = {x, x} >> n;
    return d[31:0];
  endfunction

  function automatic logic [31:0] ref_w(input logic [511:0] b, input int t);
    logic [31:0] ws [64];
    logic [31:0] a0, a1;
    for (int k = 0; k < 16; k++) ws[k] = b[511 - 32*k -: 32];
    for (int k = 16; k < 64; k++) begin
      a0 = ror(ws[k-15], 7) ^ ror(ws[k-15], 18) ^ {3'b0, ws[k-15][31:3]};
      a1 = ror(ws[k-2], 17) ^ ror(ws[k-2], 19) ^ {10'b0, ws[k-2][31:10]};
      ws[k] = a1 + ws[k-7] + a0 + ws[k-16];
    end
    return ws[t];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: w_o=%08h expected %08h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic s, input logic n);
    @(negedge clk);
    start = s; step = n;
    @(negedge clk);
    start = 1'b0; step = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 in reset", w, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", w, 32'h0);
  endtask

  task automatic t_full(input logic [511:0] b);
    blk = b;
    pulse(1'b1, 1'b0);
    check("R2 word0", w, ref_w(b, 0));
    for (int t = 1; t < 64; t++) begin
      pulse(1'b0, 1'b1);
      if (t < 16) check("R3 block word", w, ref_w(b, t));
      else        check("R5 R6 expanded word", w, ref_w(b, t));
    end
  endtask

  task automatic t_saturate(input logic [511:0] b);
    pulse(1'b0, 1'b1);
    pulse(1'b0, 1'b1);
    check("R7 step at last round", w, ref_w(b, 63));
  endtask

  task automatic t_hold(input logic [511:0] b);
    blk = b;
    pulse(1'b1, 1'b0);
    for (int t = 1; t <= 20; t++) pulse(1'b0, 1'b1);
    repeat (3) @(negedge clk);
    check("R4 idle hold", w, ref_w(b, 20));
    pulse(1'b0, 1'b1);
    check("R4 single step", w, ref_w(b, 21));
  endtask

  task automatic t_restart(input logic [511:0] b_old, input logic [511:0] b_new);
    blk = b_old;
    pulse(1'b1, 1'b0);
    for (int t = 1; t <= 30; t++) pulse(1'b0, 1'b1);
    blk = b_new;
    pulse(1'b1, 1'b0);
    check("R8 restart word0", w, ref_w(b_new, 0));
    for (int t = 1; t <= 18; t++) pulse(1'b0, 1'b1);
    check("R8 restart round18", w, ref_w(b_new, 18));
  endtask

  task automatic t_both(input logic [511:0] b);
    blk = b;
    pulse(1'b1, 1'b0);
    pulse(1'b0, 1'b1);
    pulse(1'b1, 1'b1);
    check("R2 start beats step", w, ref_w(b, 0));
    pulse(1'b0, 1'b1);
    check("R3 after start", w, ref_w(b, 1));
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: w_o=%08h expected completion", w);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic [511:0] abc, cnt_blk, ones;
    abc = '0;
    abc[511:480] = 32'h61626380;
    abc[31:0] = 32'h00000018;
    for (int k = 0; k < 16; k++)
      cnt_blk[511 - 32*k -: 32] = (32'h01010101 * (k + 1)) ^ 32'h9e3779b9;
    ones = '1;

    t_reset();
    t_full(abc);
    t_saturate(abc);
    t_full(cnt_blk);
    t_full(ones);
    t_hold(cnt_blk);
    t_restart(abc, cnt_blk);
    t_both(ones);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule